// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a misbehaving target has left stuck, with SDA held low after an interrupted transfer. When a start request arrives, the block looks at the sensed SDA level. If SDA is already high, the block finishes at once and moves neither line. If SDA is low, it pulls SCL low and releases it repeatedly through open-drain override outputs. This clocks the stuck target through the rest of its byte until it lets go of SDA. The pulse train stops early once SDA reads high, and never runs past a fixed pulse limit. After the pulses, the block forces a STOP condition using the overrides.

The controller around it starts the block after a bus error, then waits for the one-cycle completion pulse. A status flag then tells it whether the bus was found free at the end. Each half period is `HALF_TICKS` clock cycles, which the integrator sets to about 6 us at the system clock. `MAX_PULSES` sets the pulse limit.

Top module: `bus_unstick_seq`

## Requirements
- R1: If `sda_in_i` is high at the clock edge that accepts `start_i`, `done_o` pulses on the next cycle, `busy_o` never rises, both override outputs stay low, and `sda_free_o` reads 1.
- R2: Each recovery pulse holds `scl_low_o` at 1 for exactly `HALF_TICKS` cycles, followed by `HALF_TICKS` cycles with `scl_low_o` at 0 and `sda_low_o` at 0.
- R3: SDA is sampled in the last cycle of each released-SCL phase. If it reads high, no further pulse is issued, so the pulse count equals the number of SCL releases the target needs.
- R4: No more than `MAX_PULSES` recovery pulses are issued per run, even if SDA stays low throughout.
- R5: After pulsing, the block forces a STOP in three phases. First, `scl_low_o` and `sda_low_o` are both 1 for `HALF_TICKS` cycles. Next, only `sda_low_o` is 1 for `HALF_TICKS` cycles. Finally, both outputs are 0.
- R6: `done_o` is a single-cycle pulse at the end of each run. For a recovery run, `busy_o` is high from the cycle after the accepting edge for exactly 2*`HALF_TICKS`*(pulses+1) cycles, and `done_o` follows in the next cycle.
- R7: `sda_free_o` holds the SDA level sensed in the completion cycle, and keeps that value until the next run completes.
- R8: A `start_i` pulse while `busy_o` is high has no effect on the pulse count, on the phase lengths or on the result.
- R9: While `rst_n` is low, and directly after reset, `busy_o`, `done_o`, `scl_low_o`, `sda_low_o` and `sda_free_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run a recovery sequence |
| sda_in_i | input | 1 | Sensed SDA level (1 = high) |
| scl_low_o | output | 1 | 1 pulls SCL low through the open-drain override |
| sda_low_o | output | 1 | 1 pulls SDA low through the open-drain override |
| busy_o | output | 1 | Pulse or STOP phase in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sda_free_o | output | 1 | SDA was high when the last run completed |

## Verification
The hardest case to reach is a target that lets go of SDA after a chosen number of clocks. In particular, the release has to land exactly on the last allowed pulse, or one pulse too late. A proper test needs a responsive target, not a fixed input level. The bench therefore models the target: it counts SCL releases and raises the sensed SDA after a set number of them. It combines that wire with the block's own SDA override, so the STOP phases show up on the sensed level. A table of release counts walks through the immediate-free, early, limit and never-free cases. Some table rows also insert a stray start request during the run.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_STOP_A,
        ST_STOP_B,
        ST_FINISH
    } rec_state_e;

    typedef struct packed {
        rec_state_e state;
        logic       sda_free;
    } rec_regs_t;

endpackage

// File: rtl/unstick_phase_timer.sv
module unstick_phase_timer #(
    parameter int HALF_TICKS = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic expire_o
);
    localparam int TW = $clog2(HALF_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(HALF_TICKS - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || !run_i) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/unstick_pulse_counter.sv
module unstick_pulse_counter #(
    parameter int MAX_PULSES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(MAX_PULSES + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_PULSES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // the pulse now finishing is the final one allowed
    assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
    import unstick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sda_in_i,
    input  logic expire_i,
    input  logic last_pulse_i,
    output logic timer_run_o,
    output logic timer_clr_o,
    output logic pc_clr_o,
    output logic pc_inc_o,
    output logic scl_low_o,
    output logic sda_low_o,
    output logic busy_o,
    output logic done_o,
    output logic sda_free_o
);
    rec_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        timer_clr_o = 1'b0;
        pc_clr_o    = 1'b0;
        pc_inc_o    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    pc_clr_o    = 1'b1;
                    timer_clr_o = 1'b1;
                    r_d.state   = sda_in_i ? ST_FINISH : ST_CLK_LO;
                end
            end
            ST_CLK_LO: begin
                if (expire_i) begin
                    timer_clr_o = 1'b1;
                    r_d.state   = ST_CLK_HI;
                end
            end
            ST_CLK_HI: begin
                if (expire_i) begin
                    timer_clr_o = 1'b1;
                    pc_inc_o    = 1'b1;
                    r_d.state   = (sda_in_i || last_pulse_i) ? ST_STOP_A : ST_CLK_LO;
                end
            end
            ST_STOP_A: begin
                if (expire_i) begin
                    timer_clr_o = 1'b1;
                    r_d.state   = ST_STOP_B;
                end
            end
            ST_STOP_B: begin
                if (expire_i) begin
                    timer_clr_o = 1'b1;
                    r_d.state   = ST_FINISH;
                end
            end
            ST_FINISH: begin
                r_d.sda_free = sda_in_i;
                r_d.state    = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.sda_free <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign timer_run_o = (r_q.state == ST_CLK_LO) || (r_q.state == ST_CLK_HI) ||
                         (r_q.state == ST_STOP_A) || (r_q.state == ST_STOP_B);
    assign busy_o      = timer_run_o;
    assign scl_low_o   = (r_q.state == ST_CLK_LO) || (r_q.state == ST_STOP_A);
    assign sda_low_o   = (r_q.state == ST_STOP_A) || (r_q.state == ST_STOP_B);
    assign done_o      = (r_q.state == ST_FINISH);
    assign sda_free_o  = r_q.sda_free;
endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq #(
    parameter int HALF_TICKS = 600,
    parameter int MAX_PULSES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sda_in_i,
    output logic scl_low_o,
    output logic sda_low_o,
    output logic busy_o,
    output logic done_o,
    output logic sda_free_o
);
    logic timer_run, timer_clr, expire;
    logic pc_clr, pc_inc, last_pulse;

    unstick_phase_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (timer_run),
        .clr_i    (timer_clr),
        .expire_o (expire)
    );

    unstick_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_pcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pc_clr),
        .inc_i  (pc_inc),
        .last_o (last_pulse)
    );

    unstick_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .sda_in_i     (sda_in_i),
        .expire_i     (expire),
        .last_pulse_i (last_pulse),
        .timer_run_o  (timer_run),
        .timer_clr_o  (timer_clr),
        .pc_clr_o     (pc_clr),
        .pc_inc_o     (pc_inc),
        .scl_low_o    (scl_low_o),
        .sda_low_o    (sda_low_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .sda_free_o   (sda_free_o)
    );
endmodule

// File: rtl/unstick_checker.sv
module unstick_checker #(
    parameter int HALF_TICKS = 600,
    parameter int MAX_PULSES = 10
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_low_o,
    input logic sda_low_o,
    input logic busy_o,
    input logic done_o
);
    logic [15:0] lo_run_q;
    logic [15:0] pulses_q;
    logic        scl_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run_q   <= '0;
            pulses_q   <= '0;
            scl_prev_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_low_o;
            if (!scl_low_o) begin
                lo_run_q <= '0;
            end else if (lo_run_q != 16'hFFFF) begin
                lo_run_q <= lo_run_q + 16'd1;
            end
            if (!busy_o) begin
                pulses_q <= '0;
            end else if (scl_low_o && !scl_prev_q && !sda_low_o) begin
                pulses_q <= pulses_q + 16'd1;
            end
        end
    end

    // R1: no line is touched outside an active run
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_low_o && !sda_low_o));

    // R2: every low SCL phase lasts exactly one half period
    assert_low_phase_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_prev_q && !scl_low_o) |-> (lo_run_q == 16'(HALF_TICKS)));

    // R4: pulse count bounded
    assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_q <= 16'(MAX_PULSES));

    // R5: STOP starts with both lines low
    assert_stop_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> scl_low_o);

    // R5: SDA released only while SCL has been released
    assert_stop_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_low_o) |-> (!scl_low_o && !scl_prev_q));

    // R6: done is one cycle wide
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done only follows a run or an accepted start
    assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) || $past(start_i)));

    // R8: a start during a run does not abort or restart it
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind bus_unstick_seq unstick_checker #(
    .HALF_TICKS(HALF_TICKS),
    .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/sim_bus_unstick_seq.sv
`timescale 1ns/1ps
module sim_bus_unstick_seq;
    localparam int H   = 4;
    localparam int MAX = 10;
    localparam int NV  = 6;
    // releases needed by the modelled target (0 = already free, 255 = never)
    localparam int REL_N [NV] = '{0, 1, 3, 10, 11, 255};
    localparam bit POKE  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sda_in_i;
    logic scl_low_o, sda_low_o, busy_o, done_o, sda_free_o;

    int n_chk = 0;
    int n_bad = 0;

    // monitor state
    int  rel_n = 0;
    logic arm = 1'b0;
    int  rel_seen = 0;
    logic sda_slave = 1'b1;
    logic scl_prev = 1'b0;
    int  m_pulses = 0, m_busy = 0, m_both = 0, m_sdaonly = 0, m_done = 0;

    always #2.5 clk = ~clk;

    assign sda_in_i = sda_slave & ~sda_low_o;

    bus_unstick_seq #(.HALF_TICKS(H), .MAX_PULSES(MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sda_in_i(sda_in_i),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .busy_o(busy_o),
        .done_o(done_o), .sda_free_o(sda_free_o)
    );

    always @(negedge clk) begin
        if (arm) begin
            rel_seen  = 0;
            sda_slave = (rel_n == 0);
        end
        if (busy_o) m_busy++;
        if (scl_low_o && sda_low_o) m_both++;
        if (sda_low_o && !scl_low_o) m_sdaonly++;
        if (done_o) m_done++;
        if (scl_low_o && !scl_prev && !sda_low_o) m_pulses++;
        if (!scl_low_o && scl_prev && !sda_low_o) begin
            rel_seen++;
            if (rel_seen >= rel_n) sda_slave = 1'b1;
        end
        scl_prev = scl_low_o;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_one(input int rel, input bit poke);
        int p0, b0, bo0, s0, d0;
        int e_p, e_free, e_busy, e_stop;
        bit got;
        e_p    = (rel == 0) ? 0 : ((rel < MAX) ? rel : MAX);
        e_free = (rel <= MAX) ? 1 : 0;
        e_busy = (rel == 0) ? 0 : 2 * H * (e_p + 1);
        e_stop = (rel == 0) ? 0 : H;
        @(posedge clk); #1; rel_n = rel; arm = 1'b1;
        @(posedge clk); #1; arm = 1'b0;
        @(negedge clk);
        p0 = m_pulses; b0 = m_busy; bo0 = m_both; s0 = m_sdaonly; d0 = m_done;
        @(posedge clk); #1; start_i = 1'b1;
        @(posedge clk); #1; start_i = 1'b0;
        if (poke) begin
            repeat (6) @(posedge clk);
            #1; start_i = 1'b1;            // R8 stray start mid-run
            @(posedge clk); #1; start_i = 1'b0;
        end
        got = 1'b0;
        for (int i = 0; i < 4000 && !got; i++) begin
            @(negedge clk);
            if (m_done != d0) got = 1'b1;
        end
        repeat (4) @(negedge clk);
        check("R6 run completes", int'(got), 1);
        check("R3/R4 pulse count", m_pulses - p0, e_p);
        check("R7 sda_free", int'(sda_free_o), e_free);
        check("R6 busy length", m_busy - b0, e_busy);
        check("R5 both-low phase", m_both - bo0, e_stop);
        check("R5 sda-only-low phase", m_sdaonly - s0, e_stop);
        check("R6 single done", m_done - d0, 1);
        if (poke) check("R8 stray start ignored", m_pulses - p0, e_p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 outputs during reset
        check("R9 busy in reset", int'(busy_o), 0);
        check("R9 overrides in reset", int'(scl_low_o | sda_low_o), 0);
        check("R9 done/free in reset", int'(done_o | sda_free_o), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 idle after reset", int'(busy_o | done_o | scl_low_o | sda_low_o), 0);

        for (int v = 0; v < NV; v++) run_one(REL_N[v], POKE[v]);

        // R1 quick path: done exactly one cycle after the accepting edge
        @(posedge clk); #1; rel_n = 0; arm = 1'b1;
        @(posedge clk); #1; arm = 1'b0; start_i = 1'b1;
        @(posedge clk); #1; start_i = 1'b0;
        @(negedge clk);
        check("R1 quick done timing", int'(done_o), 1);
        check("R1 quick no override", int'(scl_low_o | sda_low_o | busy_o), 0);

        // R7 held: after a stuck run, flag stays 0 for many idle cycles
        run_one(255, 1'b0);
        repeat (20) @(negedge clk);
        check("R7 flag held", int'(sda_free_o), 0);

        // R2 each pulse timing: 2 pulses give exactly 2*H*3 busy cycles
        run_one(2, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule